// File: doc/BRIEF.md
# Multicycle Exception Detection Unit

This unit watches a multicycle 32-bit processor as each instruction moves through its numbered step cycles. It tests each fault source only in the step where that fault can first be seen. The instruction-fetch address is tested in step 1. Decode validity is tested in step 2. A zero divisor and a bad load/store address are tested in step 3. Arithmetic overflow is tested in step 4. An external interrupt line is tested in every step.

When any test fires, the unit takes the exception in that same cycle. It raises an abort to the step sequencer, which returns the step counter to 0. It presents a handler address for the program counter to load. It also blocks the faulting instruction's register-file and memory write enables.

On the next clock edge, a cause register takes a fixed reason code and an exception-PC register takes the address of the faulting instruction. Both keep their values until the next exception is taken.

Top module: `exc_detect_unit`

## Requirements
- R1: In step 1, a fetch address `pc_i` that is not word aligned (bits [1:0] nonzero) or is at or above `IMEM_SIZE` (default 0x4000) raises an exception with cause code 1.
- R2: In step 2, `opc_valid_i` low raises an exception with cause code 2.
- R3: In step 3, opcode 0x1A (divide) with `divisor_i` equal to zero raises an exception with cause code 3. No other opcode triggers this check.
- R4: In step 3, opcode 0x23 (load) or 0x2B (store) with a data address that is misaligned, or that lies outside [`DMEM_BASE`, `DMEM_BASE`+`DMEM_SIZE`) (default 0x1000_0000 to 0x1001_0000), raises an exception with cause code 4.
- R5: In step 4, `ovf_i` high raises an exception with cause code 5.
- R6: `irq_i` high raises an exception with cause code 0 in any step.
- R7: A fault condition present in a step other than its own has no effect: no abort, and the recorded cause and exception PC are unchanged.
- R8: When several sources fire in one cycle, the priority from highest to lowest is fetch address, opcode, divide by zero, data address, overflow, then interrupt.
- R9: In the cycle an exception is taken, `cause_o` and `epc_o` load the cause code and `pc_i`, visible after that clock edge. In every other cycle they hold their values.
- R10: `regwr_o` and `memwr_o` follow `regwr_req_i` and `memwr_req_i`, except that both are 0 in any cycle where `abort_o` is 1.
- R11: `abort_o` is 1 exactly in the cycles where an exception is taken, and `vector_o` always equals `HANDLER_ADDR` (default 0x0000_3F00). While reset is active, `abort_o` is 0 and `cause_o` and `epc_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| step_i | input | 3 | Current step number of the instruction |
| opcode_i | input | 6 | Opcode of the current instruction |
| opc_valid_i | input | 1 | Decoder reports a legal opcode |
| divisor_i | input | 32 | Second ALU operand, used as the divisor |
| ovf_i | input | 1 | ALU overflow flag |
| pc_i | input | 32 | Address of the current instruction |
| daddr_i | input | 32 | Computed data-memory address |
| irq_i | input | 1 | External interrupt request |
| regwr_req_i | input | 1 | Register-write enable requested by control |
| memwr_req_i | input | 1 | Memory-write enable requested by control |
| regwr_o | output | 1 | Gated register-write enable |
| memwr_o | output | 1 | Gated memory-write enable |
| abort_o | output | 1 | Exception taken this cycle; the sequencer resets its step to 0 |
| vector_o | output | 32 | Handler address for the program counter to load |
| cause_o | output | 3 | Recorded cause code |
| epc_o | output | 32 | Recorded faulting instruction address |

## Verification
The clocked assertions assume that the step, opcode, operands and addresses stay steady across each rising edge, and that `pc_i` names the instruction that owns the current step. The bench keeps to this by changing every input only on the falling edge. It samples combinational outputs before the next rising edge and registered outputs just after it. It also reapplies the full set of inputs for every step, so no check depends on a value left over from an earlier cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int N_SRC = 6;

  // source index = priority rank (0 highest)
  localparam int SRC_IADDR = 0;
  localparam int SRC_OPC   = 1;
  localparam int SRC_DIVZ  = 2;
  localparam int SRC_DADDR = 3;
  localparam int SRC_OVF   = 4;
  localparam int SRC_IRQ   = 5;

  localparam int IDX_W = $clog2(N_SRC);

  typedef enum logic [2:0] {
    CAUSE_IRQ   = 3'd0,
    CAUSE_IADDR = 3'd1,
    CAUSE_OPC   = 3'd2,
    CAUSE_DIVZ  = 3'd3,
    CAUSE_DADDR = 3'd4,
    CAUSE_OVF   = 3'd5
  } cause_e;

  localparam logic [5:0] OPC_DIV   = 6'h1A;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam int STEP_FETCH  = 1;
  localparam int STEP_DECODE = 2;
  localparam int STEP_EXEC   = 3;
  localparam int STEP_ALUDONE = 4;

  function automatic cause_e src_to_cause(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(SRC_IADDR): src_to_cause = CAUSE_IADDR;
      IDX_W'(SRC_OPC):   src_to_cause = CAUSE_OPC;
      IDX_W'(SRC_DIVZ):  src_to_cause = CAUSE_DIVZ;
      IDX_W'(SRC_DADDR): src_to_cause = CAUSE_DADDR;
      IDX_W'(SRC_OVF):   src_to_cause = CAUSE_OVF;
      default:           src_to_cause = CAUSE_IRQ;
    endcase
  endfunction
endpackage

// File: rtl/exc_src_check.sv
module exc_src_check
  import exc_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] IMEM_SIZE = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] DMEM_BASE = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] DMEM_SIZE = 32'h0001_0000
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [5:0]        opcode_i,
  input  logic              opc_valid_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              ovf_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic              irq_i,
  output logic [N_SRC-1:0]  hit_o
);
  localparam int AL = $clog2(WORD_BYTES);

  logic in_fetch, in_decode, in_exec, in_aludone;
  logic pc_bad, da_bad, is_mem, is_div;
  logic [ADDR_W-1:0] da_off;

  always_comb begin
    in_fetch   = (step_i == STEP_W'(STEP_FETCH));
    in_decode  = (step_i == STEP_W'(STEP_DECODE));
    in_exec    = (step_i == STEP_W'(STEP_EXEC));
    in_aludone = (step_i == STEP_W'(STEP_ALUDONE));

    is_div = (opcode_i == OPC_DIV);
    is_mem = (opcode_i == OPC_LOAD) || (opcode_i == OPC_STORE);

    pc_bad = (pc_i[AL-1:0] != '0) || (pc_i >= IMEM_SIZE);
    da_off = daddr_i - DMEM_BASE;
    da_bad = (daddr_i[AL-1:0] != '0) || (daddr_i < DMEM_BASE) || (da_off >= DMEM_SIZE);

    hit_o            = '0;
    hit_o[SRC_IADDR] = in_fetch && pc_bad;
    hit_o[SRC_OPC]   = in_decode && !opc_valid_i;
    hit_o[SRC_DIVZ]  = in_exec && is_div && (divisor_i == '0);
    hit_o[SRC_DADDR] = in_exec && is_mem && da_bad;
    hit_o[SRC_OVF]   = in_aludone && ovf_i;
    hit_o[SRC_IRQ]   = irq_i;
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int N = 6,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] free;   // free[i]: no request at index below i

  assign free[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i] = req_i[i] & free[i];
    assign free[i+1]  = free[i] & ~req_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end

  assign any_o = ~free[N];

  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(grant_o));

  // R8
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (grant_o & ~req_i) == '0);
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              take_i,
  input  cause_e            cause_i,
  input  logic [ADDR_W-1:0] pc_i,
  output cause_e            cause_o,
  output logic [ADDR_W-1:0] epc_o
);
  cause_e            cause_q, cause_d;
  logic [ADDR_W-1:0] epc_q, epc_d;
  logic              load_en;

  always_comb begin
    load_en = take_i;
    cause_d = cause_q;
    epc_d   = epc_q;
    if (load_en) begin
      cause_d = cause_i;
      epc_d   = pc_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cause_q <= CAUSE_IRQ;
      epc_q   <= '0;
    end else begin
      cause_q <= cause_d;
      epc_q   <= epc_d;
    end
  end

  assign cause_o = cause_q;
  assign epc_o   = epc_q;

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !take_i |=> ($stable(cause_q) && $stable(epc_q)));

  // R9
  epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    take_i |=> (epc_q == $past(pc_i) && cause_q == $past(cause_i)));
endmodule

// File: rtl/exc_detect_unit.sv
module exc_detect_unit
  import exc_pkg::*;
#(
  parameter int STEP_W = 3,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] IMEM_SIZE    = 32'h0000_4000,
  parameter logic [ADDR_W-1:0] DMEM_BASE    = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] DMEM_SIZE    = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 32'h0000_3F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] step_i,
  input  logic [5:0]        opcode_i,
  input  logic              opc_valid_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              ovf_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic              irq_i,
  input  logic              regwr_req_i,
  input  logic              memwr_req_i,
  output logic              regwr_o,
  output logic              memwr_o,
  output logic              abort_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic [2:0]        cause_o,
  output logic [ADDR_W-1:0] epc_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic [N_SRC-1:0] hit, grant;
  logic [IDX_W-1:0] win_idx;
  logic             any_hit, take;
  cause_e           sel_cause, rec_cause;

  exc_src_check #(
    .STEP_W(STEP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES),
    .IMEM_SIZE(IMEM_SIZE), .DMEM_BASE(DMEM_BASE), .DMEM_SIZE(DMEM_SIZE)
  ) u_src (
    .step_i(step_i), .opcode_i(opcode_i), .opc_valid_i(opc_valid_i),
    .divisor_i(divisor_i), .ovf_i(ovf_i), .pc_i(pc_i), .daddr_i(daddr_i),
    .irq_i(irq_i), .hit_o(hit)
  );

  exc_prio_enc #(.N(N_SRC)) u_prio (
    .clk(clk), .rst_sn(rst_sn), .req_i(hit),
    .grant_o(grant), .idx_o(win_idx), .any_o(any_hit)
  );

  always_comb begin
    take      = any_hit & rst_sn;
    sel_cause = src_to_cause(win_idx);
  end

  exc_state_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_sn(rst_sn), .take_i(take), .cause_i(sel_cause),
    .pc_i(pc_i), .cause_o(rec_cause), .epc_o(epc_o)
  );

  assign regwr_o  = regwr_req_i & ~take;
  assign memwr_o  = memwr_req_i & ~take;
  assign abort_o  = take;
  assign vector_o = HANDLER_ADDR;
  assign cause_o  = rec_cause;

  // R10
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    abort_o |-> (!regwr_o && !memwr_o));

  // R2
  bad_opc_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i == STEP_W'(STEP_DECODE) && !opc_valid_i) |-> abort_o);

  // R3
  divz_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i == STEP_W'(STEP_EXEC) && opcode_i == OPC_DIV && divisor_i == '0)
      |=> (cause_o == CAUSE_DIVZ));

  // R5
  ovf_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_i == STEP_W'(STEP_ALUDONE) && ovf_i) |-> abort_o);

  // R6
  irq_take_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_i |-> abort_o);

  // R9
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    abort_o |=> (epc_o == $past(pc_i)));
endmodule

// File: tb/tb_exc_detect_unit.sv
module tb_exc_detect_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] HANDLER = 32'h0000_3F00;

  typedef struct packed {
    logic [2:0]  step;
    logic [5:0]  opc;
    logic        vld;
    logic [31:0] divs;
    logic        ovf;
    logic [31:0] pc;
    logic [31:0] da;
    logic        irq;
    logic        take;
    logic [2:0]  cause;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_0100, 32'h0,          1'b0, 1'b0, 3'd0}, // R1 ok
    '{3'd1, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_0102, 32'h0,          1'b0, 1'b1, 3'd1}, // R1 misaligned
    '{3'd1, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_4000, 32'h0,          1'b0, 1'b1, 3'd1}, // R1 range
    '{3'd2, 6'h00, 1'b0, 32'd1, 1'b0, 32'h0000_0204, 32'h0,          1'b0, 1'b1, 3'd2}, // R2
    '{3'd2, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_0208, 32'h0,          1'b0, 1'b0, 3'd0}, // R2 ok
    '{3'd3, 6'h1A, 1'b1, 32'd0, 1'b0, 32'h0000_020C, 32'h0,          1'b0, 1'b1, 3'd3}, // R3
    '{3'd3, 6'h1A, 1'b1, 32'd5, 1'b0, 32'h0000_0210, 32'h0,          1'b0, 1'b0, 3'd0}, // R3 ok
    '{3'd3, 6'h23, 1'b1, 32'd1, 1'b0, 32'h0000_0214, 32'h1000_0004,  1'b0, 1'b0, 3'd0}, // R4 ok
    '{3'd3, 6'h2B, 1'b1, 32'd1, 1'b0, 32'h0000_0218, 32'h0FFF_FFFC,  1'b0, 1'b1, 3'd4}, // R4 below
    '{3'd3, 6'h23, 1'b1, 32'd1, 1'b0, 32'h0000_021C, 32'h1000_0006,  1'b0, 1'b1, 3'd4}, // R4 align
    '{3'd3, 6'h23, 1'b1, 32'd1, 1'b0, 32'h0000_0220, 32'h1001_0000,  1'b0, 1'b1, 3'd4}, // R4 end
    '{3'd3, 6'h2B, 1'b1, 32'd1, 1'b0, 32'h0000_0224, 32'h1000_FFFC,  1'b0, 1'b0, 3'd0}, // R4 last word
    '{3'd4, 6'h00, 1'b1, 32'd1, 1'b1, 32'h0000_0228, 32'h0,          1'b0, 1'b1, 3'd5}, // R5
    '{3'd0, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_022C, 32'h0,          1'b1, 1'b1, 3'd0}, // R6
    '{3'd2, 6'h00, 1'b0, 32'd1, 1'b0, 32'h0000_0230, 32'h0,          1'b1, 1'b1, 3'd2}, // R8 opc>irq
    '{3'd1, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0000_0003, 32'h0,          1'b1, 1'b1, 3'd1}, // R8 iaddr>irq
    '{3'd3, 6'h1A, 1'b1, 32'd0, 1'b1, 32'h0000_0234, 32'h0,          1'b0, 1'b1, 3'd3}, // R7 ovf off-step
    '{3'd4, 6'h00, 1'b0, 32'd1, 1'b0, 32'h0000_0238, 32'h0,          1'b0, 1'b0, 3'd0}, // R7 opc off-step
    '{3'd2, 6'h1A, 1'b1, 32'd0, 1'b1, 32'h0000_023C, 32'h0,          1'b0, 1'b0, 3'd0}, // R7 div/ovf off-step
    '{3'd0, 6'h23, 1'b1, 32'd1, 1'b0, 32'h0000_0007, 32'h0000_0005,  1'b0, 1'b0, 3'd0}, // R7 addr off-step
    '{3'd4, 6'h00, 1'b1, 32'd1, 1'b1, 32'h0000_0240, 32'h0,          1'b1, 1'b1, 3'd5}, // R8 ovf>irq
    '{3'd3, 6'h00, 1'b1, 32'd0, 1'b0, 32'h0000_0244, 32'h0000_0005,  1'b0, 1'b0, 3'd0}  // R3/R4 opcode gate
  };

  logic        clk, rst_n;
  logic [2:0]  step;
  logic [5:0]  opc;
  logic        vld, ovf, irq, rwq, mwq;
  logic [31:0] divs, pc, da;
  logic        regwr, memwr, abort;
  logic [31:0] vector, epc;
  logic [2:0]  cause;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [2:0]  m_cause;
  logic [31:0] m_epc;

  exc_detect_unit dut (
    .clk(clk), .rst_n(rst_n), .step_i(step), .opcode_i(opc), .opc_valid_i(vld),
    .divisor_i(divs), .ovf_i(ovf), .pc_i(pc), .daddr_i(da), .irq_i(irq),
    .regwr_req_i(rwq), .memwr_req_i(mwq), .regwr_o(regwr), .memwr_o(memwr),
    .abort_o(abort), .vector_o(vector), .cause_o(cause), .epc_o(epc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic wr);
    step = v.step; opc = v.opc; vld = v.vld; divs = v.divs; ovf = v.ovf;
    pc = v.pc; da = v.da; irq = v.irq; rwq = wr; mwq = wr;
  endtask

  task automatic idle();
    drive('{3'd0, 6'h00, 1'b1, 32'd1, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0}, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    irq = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 reset abort", 32'(abort), 32'd0);
    check("R11 reset cause", 32'(cause), 32'd0);
    check("R11 reset epc", epc, 32'd0);
    irq = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m_cause = 3'd0;
    m_epc   = 32'd0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i], 1'b1);
      #1;
      check($sformatf("R11 abort v%0d", i), 32'(abort), 32'(VECS[i].take));
      check($sformatf("R10 regwr v%0d", i), 32'(regwr), 32'(!VECS[i].take));
      check($sformatf("R10 memwr v%0d", i), 32'(memwr), 32'(!VECS[i].take));
      check($sformatf("R11 vector v%0d", i), vector, HANDLER);
      if (VECS[i].take) begin
        m_cause = VECS[i].cause;
        m_epc   = VECS[i].pc;
      end
      @(posedge clk);
      #1;
      check($sformatf("R9 cause v%0d", i), 32'(cause), 32'(m_cause));
      check($sformatf("R9 epc v%0d", i), epc, m_epc);
    end

    // R10 pass-through of a low request with no exception
    @(negedge clk);
    idle();
    rwq = 1'b0;
    mwq = 1'b1;
    #1;
    check("R10 regwr low passes", 32'(regwr), 32'd0);
    check("R10 memwr high passes", 32'(memwr), 32'd1);

    // R9 hold over several idle cycles after a divide fault
    @(negedge clk);
    drive(VECS[5], 1'b1);
    @(posedge clk);
    @(negedge clk);
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R9 hold cause", 32'(cause), 32'd3);
    check("R9 hold epc", epc, 32'h0000_020C);

    // R11 reset mid-run clears record
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 midrun cause", 32'(cause), 32'd0);
    check("R11 midrun epc", epc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule